// File: doc/BRIEF.md
# Delay-Sweep Edge-Search Controller

This controller measures the propagation delay of an unknown path. The delay of one programmable stage is held at its minimum. That stage drives the path under test, and the path drives the data input of a sampling flip-flop. A second programmable stage, set by a 10-bit code, clocks the same flip-flop. One trigger fires both stages. After each trigger the controller waits a set number of settle cycles and then reads the flip-flop output. A high sample means the variable stage is too slow, so the code must fall. A low sample means it is too fast, so the code must rise.

The search has two phases. A successive-approximation pass settles one bit per trial, starting at the most significant bit. After that the controller tracks in single steps until the sample alternates high and low for a chosen number of consecutive trials. It then reports the code, which maps linearly to the measured delay at 10 ps per step. If the code reaches an end of its range while the sample still asks to move past that end, the controller stops and flags a range error.

Top module: `delay_edge_search`

## Requirements
- R1: After reset, code_o, done_o, locked_o, range_err_o and trig_o are all 0.
- R2: A start_i pulse while idle clears done_o, locked_o and range_err_o in the next cycle. The first trial uses code 2^(CODE_W-1), which is 512 at default width.
- R3: trig_o is a one-cycle pulse. The sample is read SETTLE cycles after the trigger, and the next trigger follows SETTLE+1 cycles after the previous one. code_o does not change between a trigger and the read of its sample.
- R4: The approximation pass runs one trial per bit, from the MSB down to bit 0. A sample of 1 clears the bit under trial and a sample of 0 keeps it. After the bit 0 trial the controller enters tracking with the resolved code, so a full run has CODE_W approximation trials.
- R5: In tracking, a sample of 1 decrements the code and a sample of 0 increments it.
- R6: In tracking, a sample that differs from the previous tracking sample adds one to an alternation count. An equal sample, or the first tracking sample, sets the count to zero. When the count reaches LOCK_K, locked_o and done_o rise and the code of that trial is held.
- R7: In tracking, a sample of 1 at code 0, or a sample of 0 at the all-ones code, sets range_err_o and done_o and holds the code. This check takes priority over lock, and locked_o stays 0.
- R8: start_i is ignored while a measurement is in progress.
- R9: While done_o is high and no start arrives, no trigger is issued, and done_o, locked_o, range_err_o and code_o hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a measurement when idle |
| sample_i | input | 1 | Sampling flip-flop output (1 = variable stage too slow) |
| trig_o | output | 1 | One-cycle trigger for both delay stages |
| code_o | output | CODE_W | Variable stage delay code / measured result |
| done_o | output | 1 | Measurement finished |
| locked_o | output | 1 | Finished with a stable alternating edge |
| range_err_o | output | 1 | Finished because the code ran out of range |

## Verification
A start request and a sample decision can land in the same cycle. The bench holds start_i high over several trials of a running measurement, including the decision cycles. It judges the outcome by the final code and the total trigger count, which must match a run with no extra starts. Lock and range error also meet in the same decision logic: runs with the threshold at 0 and above the all-ones code must end in error without lock. A run that moves the threshold partway through tracking checks that a broken alternation sets the count back to zero.

// File: rtl/dse_pkg.sv
package dse_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FIRE = 2'd1,
        ST_WAIT = 2'd2
    } dse_state_e;

    typedef enum logic {
        PH_SAR   = 1'b0,
        PH_TRACK = 1'b1
    } dse_phase_e;
endpackage

// File: rtl/dse_settle_timer.sv
module dse_settle_timer #(
    parameter int SETTLE = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    output logic expired_o
);
    localparam int CNT_W = (SETTLE > 1) ? $clog2(SETTLE) : 1;

    typedef struct packed {
        logic             active;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (load_i) begin
            t_d.active = 1'b1;
            t_d.cnt    = CNT_W'(SETTLE - 1);
        end else if (t_q.active) begin
            if (t_q.cnt == '0) t_d.active = 1'b0;
            else               t_d.cnt    = t_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign expired_o = t_q.active && (t_q.cnt == '0);
endmodule

// File: rtl/dse_code_stepper.sv
module dse_code_stepper
    import dse_pkg::*;
#(
    parameter int CODE_W = 10,
    parameter int IDX_W  = 4
) (
    input  dse_phase_e        phase_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic              sample_i,
    output logic [CODE_W-1:0] next_code_o,
    output logic              sar_last_o,
    output logic              floor_err_o,
    output logic              ceil_err_o
);
    localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};

    logic [CODE_W-1:0] trial_bit;
    logic [CODE_W-1:0] resolved;

    always_comb begin
        trial_bit  = CODE_W'(1) << idx_i;
        resolved   = sample_i ? (code_i & ~trial_bit) : code_i;
        sar_last_o = (idx_i == '0);
        if (phase_i == PH_SAR)
            next_code_o = sar_last_o ? resolved : (resolved | (trial_bit >> 1));
        else
            next_code_o = sample_i ? (code_i - 1'b1) : (code_i + 1'b1);
        floor_err_o = (phase_i == PH_TRACK) && sample_i  && (code_i == '0);
        ceil_err_o  = (phase_i == PH_TRACK) && !sample_i && (code_i == CODE_MAX);
    end
endmodule

// File: rtl/delay_edge_search.sv
module delay_edge_search
    import dse_pkg::*;
#(
    parameter int CODE_W = 10,
    parameter int SETTLE = 4,
    parameter int LOCK_K = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              sample_i,
    output logic              trig_o,
    output logic [CODE_W-1:0] code_o,
    output logic              done_o,
    output logic              locked_o,
    output logic              range_err_o
);
    localparam int IDX_W = $clog2(CODE_W);
    localparam int ALT_W = $clog2(LOCK_K + 1);

    typedef struct packed {
        dse_state_e        st;
        dse_phase_e        ph;
        logic [CODE_W-1:0] code;
        logic [IDX_W-1:0]  idx;
        logic [ALT_W-1:0]  alt;
        logic              prev;
        logic              have_prev;
        logic              done;
        logic              locked;
        logic              rerr;
    } regs_t;

    regs_t r_d, r_q;

    logic              settled;
    logic [CODE_W-1:0] step_code;
    logic              sar_last;
    logic              floor_err;
    logic              ceil_err;
    logic [ALT_W-1:0]  alt_next;

    assign trig_o = (r_q.st == ST_FIRE);

    dse_settle_timer #(.SETTLE(SETTLE)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (trig_o),
        .expired_o (settled)
    );

    dse_code_stepper #(.CODE_W(CODE_W), .IDX_W(IDX_W)) u_step (
        .phase_i     (r_q.ph),
        .code_i      (r_q.code),
        .idx_i       (r_q.idx),
        .sample_i    (sample_i),
        .next_code_o (step_code),
        .sar_last_o  (sar_last),
        .floor_err_o (floor_err),
        .ceil_err_o  (ceil_err)
    );

    // alternation count: grows on a change of sample, restarts otherwise
    assign alt_next = (r_q.have_prev && (sample_i != r_q.prev)) ? r_q.alt + 1'b1 : '0;

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.st        = ST_FIRE;
                    r_d.ph        = PH_SAR;
                    r_d.code      = CODE_W'(1) << (CODE_W - 1);
                    r_d.idx       = IDX_W'(CODE_W - 1);
                    r_d.alt       = '0;
                    r_d.have_prev = 1'b0;
                    r_d.done      = 1'b0;
                    r_d.locked    = 1'b0;
                    r_d.rerr      = 1'b0;
                end
            end
            ST_FIRE: r_d.st = ST_WAIT;
            ST_WAIT: begin
                if (settled) begin
                    if (r_q.ph == PH_SAR) begin
                        r_d.code = step_code;
                        r_d.st   = ST_FIRE;
                        if (sar_last) r_d.ph  = PH_TRACK;
                        else          r_d.idx = r_q.idx - 1'b1;
                    end else if (floor_err || ceil_err) begin
                        r_d.rerr = 1'b1;
                        r_d.done = 1'b1;
                        r_d.st   = ST_IDLE;
                    end else begin
                        r_d.prev      = sample_i;
                        r_d.have_prev = 1'b1;
                        r_d.alt       = alt_next;
                        if (alt_next == ALT_W'(LOCK_K)) begin
                            r_d.locked = 1'b1;
                            r_d.done   = 1'b1;
                            r_d.st     = ST_IDLE;
                        end else begin
                            r_d.code = step_code;
                            r_d.st   = ST_FIRE;
                        end
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
            r_q.ph <= PH_SAR;
        end else begin
            r_q <= r_d;
        end
    end

    assign code_o      = r_q.code;
    assign done_o      = r_q.done;
    assign locked_o    = r_q.locked;
    assign range_err_o = r_q.rerr;
endmodule

// File: rtl/dse_checker.sv
module dse_checker #(
    parameter int CODE_W = 10,
    parameter int SETTLE = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              trig_o,
    input logic [CODE_W-1:0] code_o,
    input logic              done_o,
    input logic              locked_o,
    input logic              range_err_o
);
    localparam int GAP_W = $clog2(SETTLE + 3);
    localparam logic [GAP_W-1:0] GAP_SAT = GAP_W'(SETTLE + 2);

    logic [GAP_W-1:0] gap_q;
    logic             seen_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else if (trig_o) begin
            gap_q  <= GAP_W'(1);
            seen_q <= 1'b1;
        end else if (gap_q != GAP_SAT) begin
            gap_q  <= gap_q + 1'b1;
        end
    end

    assert_trig_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        trig_o |=> !trig_o);
    assert_code_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        trig_o |=> $stable(code_o));
    assert_trig_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_o && seen_q) |-> (gap_q >= GAP_W'(SETTLE + 1)));
    assert_flags_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (locked_o || range_err_o) |-> done_o);
    assert_err_no_lock_R7: assert property (@(posedge clk) disable iff (!rst_n)
        range_err_o |-> !locked_o);
    assert_quiet_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !trig_o);
    assert_done_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> (done_o && $stable(code_o) && $stable(locked_o)));
    assert_start_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && start_i) |=> (!done_o && !locked_o && !range_err_o));
endmodule

bind delay_edge_search dse_checker #(.CODE_W(CODE_W), .SETTLE(SETTLE)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .trig_o      (trig_o),
    .code_o      (code_o),
    .done_o      (done_o),
    .locked_o    (locked_o),
    .range_err_o (range_err_o)
);

// File: tb/delay_edge_search_tb.sv
module delay_edge_search_tb;
    localparam int CODE_W = 10;
    localparam int SETTLE = 4;
    localparam int LOCK_K = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic              sample_i;
    logic              trig_o;
    logic [CODE_W-1:0] code_o;
    logic              done_o;
    logic              locked_o;
    logic              range_err_o;

    int thr = 0;
    int n_chk = 0;
    int n_fail = 0;
    int trig_cnt;
    int first_code;
    int t_first;
    int t_second;

    always #10 clk = ~clk;

    // path model: sample high when the variable stage is slower than the path
    assign sample_i = (int'(code_o) >= thr);

    delay_edge_search #(.CODE_W(CODE_W), .SETTLE(SETTLE), .LOCK_K(LOCK_K)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .sample_i    (sample_i),
        .trig_o      (trig_o),
        .code_o      (code_o),
        .done_o      (done_o),
        .locked_o    (locked_o),
        .range_err_o (range_err_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // one measurement; optional threshold shift at trigger 13, optional busy starts
    task automatic run_meas(input int t0, input bit shift, input int t1, input bit busy);
        int n = 0;
        thr = t0;
        trig_cnt = 0; first_code = -1; t_first = 0; t_second = 0;
        start_i = 1'b1;
        forever begin
            @(negedge clk);
            n++;
            if (n == 1) begin
                chk(!done_o && !locked_o && !range_err_o, "R2 flags cleared", {done_o, locked_o, range_err_o}, 0);
            end
            if (trig_o) begin
                trig_cnt++;
                if (trig_cnt == 1) begin first_code = int'(code_o); t_first = n; end
                if (trig_cnt == 2) t_second = n;
                if (shift && trig_cnt == 13) thr = t1;
            end
            start_i = busy && trig_cnt >= 3 && trig_cnt <= 6;
            if (done_o && n > 1) break;
            if (n > 5000) begin
                chk(1'b0, "watchdog run", n, 5000);
                break;
            end
        end
        start_i = 1'b0;
    endtask

    task automatic t_reset;
        chk(code_o == '0, "R1 code", int'(code_o), 0);
        chk(!done_o, "R1 done", done_o, 0);
        chk(!locked_o && !range_err_o, "R1 flags", {locked_o, range_err_o}, 0);
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            chk(!trig_o, "R1 R9 no trigger idle", trig_o, 0);
        end
    endtask

    task automatic t_basic;
        run_meas(500, 1'b0, 0, 1'b0);
        chk(first_code == 512, "R2 first code", first_code, 512);
        chk(t_second - t_first == SETTLE + 1, "R3 trigger spacing", t_second - t_first, SETTLE + 1);
        chk(locked_o && !range_err_o, "R6 locked", {locked_o, range_err_o}, 2);
        chk(int'(code_o) == 499, "R4 R6 result code", int'(code_o), 499);
        chk(trig_cnt == CODE_W + LOCK_K + 1, "R4 R5 trial count", trig_cnt, CODE_W + LOCK_K + 1);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            chk(done_o && !trig_o && int'(code_o) == 499 && locked_o, "R9 hold", int'(code_o), 499);
        end
    endtask

    task automatic t_lock_edges;
        run_meas(1, 1'b0, 0, 1'b0);
        chk(locked_o && int'(code_o) == 0, "R4 R5 low edge lock", int'(code_o), 0);
        run_meas(1023, 1'b0, 0, 1'b0);
        chk(locked_o && int'(code_o) == 1022, "R4 R5 high edge lock", int'(code_o), 1022);
    endtask

    task automatic t_range;
        run_meas(0, 1'b0, 0, 1'b0);
        chk(range_err_o && !locked_o, "R7 floor error", {range_err_o, locked_o}, 2);
        chk(int'(code_o) == 0, "R7 floor code", int'(code_o), 0);
        chk(trig_cnt == CODE_W + 1, "R7 floor trials", trig_cnt, CODE_W + 1);
        run_meas(1100, 1'b0, 0, 1'b0);
        chk(range_err_o && !locked_o, "R7 ceiling error", {range_err_o, locked_o}, 2);
        chk(int'(code_o) == 1023, "R7 ceiling code", int'(code_o), 1023);
        chk(trig_cnt == CODE_W + 1, "R7 ceiling trials", trig_cnt, CODE_W + 1);
    endtask

    task automatic t_realign;
        // tracking: 499 L,500 H,(move to 503) 499 L,500 L,501 L,502 L,503 H,502 L,503 H,502 L
        run_meas(500, 1'b1, 503, 1'b0);
        chk(locked_o && int'(code_o) == 502, "R6 count restart code", int'(code_o), 502);
        chk(trig_cnt == CODE_W + 10, "R6 count restart trials", trig_cnt, CODE_W + 10);
    endtask

    task automatic t_busy_start;
        run_meas(500, 1'b0, 0, 1'b1);
        chk(locked_o && int'(code_o) == 499, "R8 busy start code", int'(code_o), 499);
        chk(trig_cnt == CODE_W + LOCK_K + 1, "R8 busy start trials", trig_cnt, CODE_W + LOCK_K + 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_lock_edges();
        t_range();
        t_realign();
        t_busy_start();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule